// File: doc/BRIEF.md
# Asymmetric Dual-Port Shared Memory with Port-A Priority

This block is a word-organised memory reached from two sides at once. Port A is a full-word port, 16 bits by default, driven by the dispatch logic. Port B is a narrow byte port, 8 bits by default, driven by a host processor. Both ports can read and write. Each port B byte address selects one lane of a word. Byte address `2k` is the low byte `[7:0]` of word `k`, and byte address `2k+1` is its high byte `[15:8]`.

A collision occurs when both ports are enabled in the same cycle and port B's word address (byte address shifted right by one) equals port A's word address. On a collision, port A goes ahead unchanged. Port B sees `b_busy` high in that same cycle. Port B's write is dropped and its read does not complete. Port B has to repeat the access in a later cycle. When the two ports address different words, both accesses complete in the same cycle with no stall.

Reads take one cycle on both ports. Read data is registered and keeps its value until the next read on that port completes. A write does not change the read register of the port that writes.

Top module: `asym_dpram`

## Requirements
- R1: After a cycle with `rst_n` low, `a_rdata` and `b_rdata` are both zero.
- R2: A port A read (`a_en`=1, `a_we`=0) places the addressed word on `a_rdata` one clock edge later, including the data from an earlier port A write.
- R3: Port B byte address `2k` maps to bits `[7:0]` of word `k`, and byte address `2k+1` maps to bits `[15:8]`. This holds for both reads and writes.
- R4: A word written through port A can be read back byte by byte through port B. The read data appears on `b_rdata` one clock edge after the request.
- R5: `b_busy` is high in a cycle exactly when `a_en` and `b_en` are both high and `b_addr>>1` equals `a_addr`. It is combinational, so it is valid in the same cycle as the request.
- R6: In a collision cycle, port B's write is not performed and `b_rdata` keeps its previous value. Port A's access completes normally.
- R7: If port A writes a word while port B's read of that same word is refused, port B's retried read returns the new data.
- R8: When both ports are enabled on different words, `b_busy` stays low and both accesses complete in that cycle.
- R9: `a_rdata` changes only after a port A read. `b_rdata` changes only after a port B read that was not refused.
- R10: A port B byte write leaves the other byte of the same word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the read registers |
| a_en | input | 1 | Port A access request |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | 6 | Port A word address |
| a_wdata | input | 16 | Port A write word |
| a_rdata | output | 16 | Port A registered read word |
| b_en | input | 1 | Port B access request |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | 7 | Port B byte address |
| b_wdata | input | 8 | Port B write byte |
| b_rdata | output | 8 | Port B registered read byte |
| b_busy | output | 1 | Port B refused this cycle and must retry |

## Verification
A wrong collision decision shows at the ports in one of two ways. A refusal that should not happen shows on `b_busy` in the same cycle. A missed refusal lets the byte write land in storage, and a later port A read of that word shows the wrong byte one edge after it is issued. A wrong lane select, or a write-enable reaching the wrong lane, corrupts the neighbouring byte. That error shows on the next read of the full word. A read register that updates when it should not changes `b_rdata` or `a_rdata` one edge after an idle or refused cycle. The bench therefore checks these outputs after every stimulus row.

// File: rtl/dpr_pkg.sv
// Package dpr_pkg
// Shared helpers for the asymmetric dual-port memory.
// Assumes the wide port width is a whole multiple (at least 2) of the narrow width.
package dpr_pkg;

    // Number of narrow lanes in one wide word
    function automatic int lane_count(input int wide_w, input int narrow_w);
        return wide_w / narrow_w;
    endfunction

    // Width of the lane-select field carried in the low bits of a narrow address
    function automatic int lane_sel_width(input int wide_w, input int narrow_w);
        return $clog2(wide_w / narrow_w);
    endfunction

endpackage

// File: rtl/dpr_collide.sv
// Module dpr_collide
// Flags a same-word access by both ports in one cycle. Port A always wins,
// so the flag is the refusal for port B.
// Assumes word addresses of both ports have equal width.
module dpr_collide #(
    parameter int WORD_AW = 6
) (
    input  logic               a_en,
    input  logic [WORD_AW-1:0] a_word,
    input  logic               b_en,
    input  logic [WORD_AW-1:0] b_word,
    output logic               b_refuse
);

    // Same word, both enabled: port B is held off
    always_comb begin
        b_refuse = a_en && b_en && (a_word == b_word);
    end

endmodule

// File: rtl/dpr_lane_store.sv
// Module dpr_lane_store
// Storage for one narrow lane of every word, with one write and one
// asynchronous read path per port. Contents are not reset.
// Assumes the two write addresses never match when both writes are on,
// which the collision logic above it guarantees.
module dpr_lane_store #(
    parameter int WORD_AW = 6,
    parameter int LANE_W  = 8
) (
    input  logic               clk,
    input  logic               a_wr,
    input  logic [WORD_AW-1:0] a_word,
    input  logic [LANE_W-1:0]  a_wbits,
    output logic [LANE_W-1:0]  a_q,
    input  logic               b_wr,
    input  logic [WORD_AW-1:0] b_word,
    input  logic [LANE_W-1:0]  b_wbits,
    output logic [LANE_W-1:0]  b_q
);

    localparam int DEPTH = 1 << WORD_AW;

    logic [LANE_W-1:0] cells [DEPTH];

    // Commit writes from either port into this lane
    always_ff @(posedge clk) begin
        if (a_wr) cells[a_word] <= a_wbits;
        if (b_wr) cells[b_word] <= b_wbits;
    end

    // Present the addressed lane to each port
    always_comb begin
        a_q = cells[a_word];
        b_q = cells[b_word];
    end

endmodule

// File: rtl/dpr_bport_read.sv
// Module dpr_bport_read
// Picks the addressed lane out of a word for port B and holds it in a
// register. The register changes only on an accepted port B read.
// Assumes the lane select is the low field of the byte address.
module dpr_bport_read #(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8,
    parameter int LSEL_W   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_req,
    input  logic                refused,
    input  logic [LSEL_W-1:0]   lane_sel,
    input  logic [WIDE_W-1:0]   word_q,
    output logic [NARROW_W-1:0] b_rdata
);

    logic [NARROW_W-1:0] picked;

    // Select one narrow lane of the word
    always_comb begin
        picked = word_q[lane_sel*NARROW_W +: NARROW_W];
    end

    // Capture the lane on an accepted read, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_rdata <= '0;
        end else if (rd_req && !refused) begin
            b_rdata <= picked;
        end
    end

    AST_B_HOLD_WHEN_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> $stable(b_rdata)); // R6
    AST_B_HOLD_WHEN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(b_rdata)); // R9

endmodule

// File: rtl/asym_dpram.sv
// Module asym_dpram
// Shared memory with a wide port A and a narrow port B. Port A has fixed
// priority on a same-word collision, and port B is told to retry through
// b_busy. Both ports read with one cycle of latency.
// Assumes DATA_A_W is DATA_B_W times a power of two, at least 2.
module asym_dpram #(
    parameter int WORD_AW  = 6,
    parameter int DATA_A_W = 16,
    parameter int DATA_B_W = 8,
    localparam int LANES   = dpr_pkg::lane_count(DATA_A_W, DATA_B_W),
    localparam int LSEL_W  = dpr_pkg::lane_sel_width(DATA_A_W, DATA_B_W),
    localparam int BYTE_AW = WORD_AW + LSEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                a_en,
    input  logic                a_we,
    input  logic [WORD_AW-1:0]  a_addr,
    input  logic [DATA_A_W-1:0] a_wdata,
    output logic [DATA_A_W-1:0] a_rdata,
    input  logic                b_en,
    input  logic                b_we,
    input  logic [BYTE_AW-1:0]  b_addr,
    input  logic [DATA_B_W-1:0] b_wdata,
    output logic [DATA_B_W-1:0] b_rdata,
    output logic                b_busy
);

    logic [WORD_AW-1:0]  b_word;
    logic [LSEL_W-1:0]   b_lane;
    logic                b_write_ok;
    logic [DATA_A_W-1:0] a_word_q;
    logic [DATA_A_W-1:0] b_word_q;

    // Split the port B byte address into word and lane
    always_comb begin
        b_word = b_addr[BYTE_AW-1:LSEL_W];
        b_lane = b_addr[LSEL_W-1:0];
    end

    dpr_collide #(.WORD_AW(WORD_AW)) u_collide (
        .a_en     (a_en),
        .a_word   (a_addr),
        .b_en     (b_en),
        .b_word   (b_word),
        .b_refuse (b_busy)
    );

    // A port B write proceeds only when not refused
    always_comb begin
        b_write_ok = b_en && b_we && !b_busy;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic lane_b_wr;

        // Port B writes only the lane it addresses
        always_comb begin
            lane_b_wr = b_write_ok && (b_lane == LSEL_W'(g));
        end

        dpr_lane_store #(.WORD_AW(WORD_AW), .LANE_W(DATA_B_W)) u_store (
            .clk     (clk),
            .a_wr    (a_en && a_we),
            .a_word  (a_addr),
            .a_wbits (a_wdata[g*DATA_B_W +: DATA_B_W]),
            .a_q     (a_word_q[g*DATA_B_W +: DATA_B_W]),
            .b_wr    (lane_b_wr),
            .b_word  (b_word),
            .b_wbits (b_wdata),
            .b_q     (b_word_q[g*DATA_B_W +: DATA_B_W])
        );
    end

    // Register the port A read word, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
        end else if (a_en && !a_we) begin
            a_rdata <= a_word_q;
        end
    end

    dpr_bport_read #(.WIDE_W(DATA_A_W), .NARROW_W(DATA_B_W), .LSEL_W(LSEL_W)) u_bread (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (b_en && !b_we),
        .refused  (b_busy),
        .lane_sel (b_lane),
        .word_q   (b_word_q),
        .b_rdata  (b_rdata)
    );

    AST_A_HOLD_WHEN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_en && !a_we) |=> $stable(a_rdata)); // R9
    AST_BUSY_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        b_busy |-> (a_en && b_en)); // R5
    AST_NO_BUSY_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && b_en && (b_addr[BYTE_AW-1:LSEL_W] != a_addr)) |-> !b_busy); // R8
    AST_BUSY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && b_en && (b_addr[BYTE_AW-1:LSEL_W] == a_addr)) |-> b_busy); // R5

endmodule

// File: tb/asym_dpram_bench.sv
module asym_dpram_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        a_en, a_we, b_en, b_we;
    logic [5:0]  a_addr;
    logic [15:0] a_wdata, a_rdata;
    logic [6:0]  b_addr;
    logic [7:0]  b_wdata, b_rdata;
    logic        b_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk; // 200 MHz

    asym_dpram u_asym_dpram (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
        .b_busy(b_busy)
    );

    // Row: {a_en,a_we,a_addr6,a_wdata16, b_en,b_we,b_addr7,b_wdata8,
    //       exp_busy, chk_a,exp_a16, chk_b,exp_b8} = 68 bits
    localparam int NROW = 16;
    localparam logic [67:0] ROWS [NROW] = '{
        {1'b1,1'b1,6'd3,16'hBEEF, 1'b0,1'b0,7'd0,8'h00,  1'b0, 1'b0,16'h0000, 1'b0,8'h00}, // A write w3
        {1'b1,1'b0,6'd3,16'h0000, 1'b0,1'b0,7'd0,8'h00,  1'b0, 1'b1,16'hBEEF, 1'b0,8'h00}, // R2
        {1'b0,1'b0,6'd0,16'h0000, 1'b1,1'b0,7'd6,8'h00,  1'b0, 1'b0,16'h0000, 1'b1,8'hEF}, // R4 low
        {1'b0,1'b0,6'd0,16'h0000, 1'b1,1'b0,7'd7,8'h00,  1'b0, 1'b0,16'h0000, 1'b1,8'hBE}, // R4 high
        {1'b1,1'b1,6'd2,16'h1111, 1'b1,1'b1,7'd10,8'h12, 1'b0, 1'b0,16'h0000, 1'b0,8'h00}, // R8
        {1'b1,1'b0,6'd2,16'h0000, 1'b1,1'b1,7'd11,8'h34, 1'b0, 1'b1,16'h1111, 1'b0,8'h00}, // R8
        {1'b1,1'b0,6'd5,16'h0000, 1'b0,1'b0,7'd0,8'h00,  1'b0, 1'b1,16'h3412, 1'b0,8'h00}, // R3
        {1'b0,1'b0,6'd0,16'h0000, 1'b1,1'b1,7'd10,8'h56, 1'b0, 1'b0,16'h0000, 1'b0,8'h00},
        {1'b1,1'b0,6'd5,16'h0000, 1'b0,1'b0,7'd0,8'h00,  1'b0, 1'b1,16'h3456, 1'b0,8'h00}, // R10
        {1'b1,1'b1,6'd5,16'hA0A1, 1'b1,1'b1,7'd11,8'hFF, 1'b1, 1'b0,16'h0000, 1'b0,8'h00}, // R6 collide
        {1'b1,1'b0,6'd5,16'h0000, 1'b1,1'b0,7'd6,8'h00,  1'b0, 1'b1,16'hA0A1, 1'b1,8'hEF}, // R6 dropped
        {1'b1,1'b0,6'd5,16'h0000, 1'b1,1'b0,7'd10,8'h00, 1'b1, 1'b1,16'hA0A1, 1'b1,8'hEF}, // R6 hold
        {1'b0,1'b0,6'd0,16'h0000, 1'b1,1'b0,7'd10,8'h00, 1'b0, 1'b0,16'h0000, 1'b1,8'hA1}, // retry
        {1'b1,1'b1,6'd3,16'h7788, 1'b1,1'b0,7'd7,8'h00,  1'b1, 1'b0,16'h0000, 1'b1,8'hA1}, // R7 refused
        {1'b0,1'b0,6'd0,16'h0000, 1'b1,1'b0,7'd7,8'h00,  1'b0, 1'b0,16'h0000, 1'b1,8'h77}, // R7 retry
        {1'b0,1'b0,6'd0,16'h0000, 1'b0,1'b0,7'd0,8'h00,  1'b0, 1'b1,16'hA0A1, 1'b1,8'h77}  // R9 idle
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0;
        b_en = 0; b_we = 0; b_addr = '0; b_wdata = '0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(a_rdata == 16'h0, "R1 a_rdata", a_rdata, 16'h0);
        check(b_rdata == 8'h0, "R1 b_rdata", {8'h0, b_rdata}, 16'h0);
        rst_n = 1;

        for (int i = 0; i < NROW; i++) begin
            logic [67:0] r;
            r = ROWS[i];
            a_en = r[67]; a_we = r[66]; a_addr = r[65:60]; a_wdata = r[59:44];
            b_en = r[43]; b_we = r[42]; b_addr = r[41:35]; b_wdata = r[34:27];
            #1;
            check(b_busy == r[26], "R5 b_busy", {15'h0, b_busy}, {15'h0, r[26]});
            @(posedge clk);
            #1;
            if (r[25]) check(a_rdata == r[24:9], "R2/R3 a_rdata", a_rdata, r[24:9]);
            if (r[8])  check(b_rdata == r[7:0], "R4/R7 b_rdata", {8'h0, b_rdata}, {8'h0, r[7:0]});
            @(negedge clk);
        end

        // Directed: lane mapping of a port B write at an even byte address (R3)
        idle_inputs();
        b_en = 1; b_we = 1; b_addr = 7'd40; b_wdata = 8'hC3;
        @(negedge clk);
        b_en = 0; b_we = 0; a_en = 1; a_addr = 6'd20; a_wdata = '0;
        @(negedge clk);
        check(a_rdata[7:0] == 8'hC3, "R3 even byte to low lane", {8'h0, a_rdata[7:0]}, 16'h00C3);

        // Directed: reset mid-run clears both read registers (R1)
        idle_inputs();
        rst_n = 0;
        @(negedge clk);
        check(a_rdata == 16'h0, "R1 mid-run a_rdata", a_rdata, 16'h0);
        check(b_rdata == 8'h0, "R1 mid-run b_rdata", {8'h0, b_rdata}, 16'h0);
        rst_n = 1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule